// File: doc/BRIEF.md
# DRAM Channel Steering and Address Normalizer

This block takes a system address that is already known to belong to the local memory node. It also takes that node's controller-select settings. From these it picks one of two DRAM channels, and it turns the system address into the address that channel sees.

It applies one of several channel policies: ganged operation, a dedicated high range, plain bit interleave, and hashed interleave. It then subtracts the right base for the address. That base is the node range base, the relocated-hole offset, or the high-range offset. Finally it squeezes out the address bits consumed by node interleaving and by channel interleaving.

The logic is combinational. One register stage sits at the output, and a valid flag accompanies the result.

Top module: `dram_chan_norm`

## Requirements
- R1: All outputs are registered. `outValid` is `inValid` delayed by one clock. The other outputs load only in a cycle where `inValid` is 1, and hold their value otherwise. Reset clears every output to 0.
- R2: `hiRange` is 1 exactly when all three hold:
  - `hiRangeEn` is 1;
  - `ganged` is 0;
  - `sysAddr` is at or above `selBase` times 2^27.
- R3: With `ganged` set, the channel is `sysAddr` bit 3. This takes precedence over every other policy.
- R4: In the high range, the channel is `hiSel`. If no earlier policy applies and `ilvEn` is 0, the channel is the inverse of `hiSel` when `hiRangeEn` is 1, and 0 otherwise.
- R5: With `ilvEn` set and `ilvMode` = 0, the channel is `sysAddr` bit 6. With `ilvMode` = 1, the channel is `sysAddr` bit (12 + `nodeIlvBits`).
- R6: With `ilvEn` set and `ilvMode` bit 1 set, the channel is the XOR of `sysAddr` bits 20 down to 16, XORed again with a second bit. That bit is `sysAddr` bit 9 when `ilvMode` bit 0 is 1, and `sysAddr` bit 6 otherwise.
- R7: In the high range, the subtracted offset is the hole offset (`holeOfs` times 2^23) when all three hold:
  - `selBase`·2^27 is below `holeBase`·2^24;
  - `holeValid` is 1;
  - `sysAddr` is at least 2^32.
  Otherwise the offset is `selOfs` times 2^26.
- R8: Outside the high range, the offset is the hole offset when `holeValid` is 1 and `sysAddr` is at least 2^32. Otherwise the offset is `rangeBase`.
- R9: After the subtraction, `nodeIlvBits` bits starting at bit 12 are removed. Higher bits shift down, and bits 11..0 are kept.
- R10: Channel interleave removal happens only when `ilvEn` is 1, `hiRange` is 0 and `ganged` is 0. It then deletes one bit of the node-compacted address:
  - bit 6 for `ilvMode` 0 or 2;
  - bit 12 for mode 1;
  - bit 9 for mode 3.
- R11: `underflow` is 1 when the chosen offset exceeds `sysAddr`. In that case `chanAddr` still carries the 48-bit wrapped difference, compacted as above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input qualifier |
| sysAddr | input | ADDR_W | Node-resolved system address |
| nodeIlvBits | input | 2 | Number of node interleave bits (0..3) |
| rangeBase | input | ADDR_W | Base of the node's DRAM range |
| holeValid | input | 1 | Relocated I/O hole is active |
| holeBase | input | HOLE_BASE_W | Hole base, in 16 MiB units |
| holeOfs | input | HOLE_OFS_W | Hole offset, in 8 MiB units |
| hiRangeEn | input | 1 | High channel range enable |
| hiSel | input | 1 | Channel owning the high range |
| ganged | input | 1 | Both channels operate as one |
| ilvEn | input | 1 | Channel interleave enable |
| ilvMode | input | 2 | Channel interleave policy |
| selBase | input | ADDR_W-27 | High range start, in 128 MiB units |
| selOfs | input | ADDR_W-26 | High range offset, in 64 MiB units |
| outValid | output | 1 | Result valid |
| chanSel | output | 1 | Selected channel |
| hiRange | output | 1 | Address lies in the high range |
| chanAddr | output | ADDR_W | Normalized channel address |
| underflow | output | 1 | Offset exceeded the address |

## Verification
The bench aims at the edge of the high range, one unit below and exactly at `selBase`·2^27. A design with an off-by-one compare there flips `hiRange`, the channel and the offset. It probes the 4 GiB boundary with the hole enabled. A mistake there subtracts the wrong base and shifts the whole channel address.

Hash cases use odd and even parity of bits 20..16 with both partner bits. A missing XOR term then inverts the channel. Every `nodeIlvBits` value is combined with each interleave mode, so dropping the wrong bit, or dropping it in the high range, shows up as a corrupted `chanAddr`. Holding `inValid` low with new inputs exposes any output register that loads unqualified.

// File: rtl/chan_norm_pkg.sv
package chan_norm_pkg;
  localparam int SEL_BASE_SH  = 27;
  localparam int SEL_OFS_SH   = 26;
  localparam int HOLE_OFS_SH  = 23;
  localparam int HOLE_BASE_SH = 24;
  localparam int NODE_ILV_LSB = 12;
  localparam int FOUR_GIB_BIT = 32;

  typedef enum logic [1:0] {OFS_RANGE, OFS_HOLE, OFS_SEL} ofsSel_e;
  typedef enum logic [1:0] {DROP_NONE, DROP_B6, DROP_B9, DROP_B12} dropSel_e;

  typedef struct packed {
    logic     hiRange;
    logic     chan;
    ofsSel_e  ofsSel;
    dropSel_e dropSel;
  } ctrlStrb_t;
endpackage

// File: rtl/chan_norm_ctrl.sv
module chan_norm_ctrl
  import chan_norm_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int SEL_BASE_W  = 21,
  parameter int HOLE_BASE_W = 8
) (
  input  logic [ADDR_W-1:0]      sysAddr,
  input  logic [1:0]             nodeIlvBits,
  input  logic                   holeValid,
  input  logic [HOLE_BASE_W-1:0] holeBase,
  input  logic                   hiRangeEn,
  input  logic                   hiSel,
  input  logic                   ganged,
  input  logic                   ilvEn,
  input  logic [1:0]             ilvMode,
  input  logic [SEL_BASE_W-1:0]  selBase,
  output ctrlStrb_t              strb
);
  logic [ADDR_W-1:0] selBaseAddr;
  logic [ADDR_W-1:0] holeBaseAddr;
  logic [ADDR_W-1:0] nodeShifted;
  logic              above4G;
  logic              hashPar;
  logic              hiSelected;

  assign selBaseAddr  = ADDR_W'(selBase) << SEL_BASE_SH;
  assign holeBaseAddr = ADDR_W'(holeBase) << HOLE_BASE_SH;
  assign nodeShifted  = sysAddr >> (NODE_ILV_LSB + int'(nodeIlvBits));
  assign above4G      = |sysAddr[ADDR_W-1:FOUR_GIB_BIT];
  assign hashPar      = ^sysAddr[20:16];
  assign hiSelected   = hiRangeEn && !ganged && (sysAddr >= selBaseAddr);

  always_comb begin
    strb.hiRange = hiSelected;

    // channel policy, highest priority first
    if (ganged)                          strb.chan = sysAddr[3];
    else if (hiSelected)                 strb.chan = hiSel;
    else if (ilvEn && ilvMode == 2'd0)   strb.chan = sysAddr[6];
    else if (ilvEn && ilvMode[1])        strb.chan = hashPar ^ (ilvMode[0] ? sysAddr[9] : sysAddr[6]);
    else if (ilvEn)                      strb.chan = nodeShifted[0];
    else if (hiRangeEn)                  strb.chan = ~hiSel;
    else                                 strb.chan = 1'b0;

    // offset source
    if (hiSelected)
      strb.ofsSel = ((selBaseAddr < holeBaseAddr) && holeValid && above4G) ? OFS_HOLE : OFS_SEL;
    else
      strb.ofsSel = (holeValid && above4G) ? OFS_HOLE : OFS_RANGE;

    // channel interleave bit removal
    if (ilvEn && !hiSelected && !ganged) begin
      if (!ilvMode[0])           strb.dropSel = DROP_B6;
      else if (ilvMode == 2'd1)  strb.dropSel = DROP_B12;
      else                       strb.dropSel = DROP_B9;
    end else begin
      strb.dropSel = DROP_NONE;
    end
  end
endmodule

// File: rtl/chan_norm_dpath.sv
module chan_norm_dpath
  import chan_norm_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int HOLE_OFS_W = 9,
  parameter int SEL_OFS_W  = 22
) (
  input  logic [ADDR_W-1:0]     sysAddr,
  input  logic [1:0]            nodeIlvBits,
  input  logic [ADDR_W-1:0]     rangeBase,
  input  logic [HOLE_OFS_W-1:0] holeOfs,
  input  logic [SEL_OFS_W-1:0]  selOfs,
  input  ctrlStrb_t             strb,
  output logic [ADDR_W-1:0]     chanAddr,
  output logic                  underflow
);
  localparam logic [ADDR_W-1:0] LOW_KEEP = (ADDR_W'(1) << NODE_ILV_LSB) - ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] dropBit(input logic [ADDR_W-1:0] a, input int pos);
    logic [ADDR_W-1:0] keep;
    keep = (ADDR_W'(1) << pos) - ADDR_W'(1);
    return ((a >> (pos + 1)) << pos) | (a & keep);
  endfunction

  logic [ADDR_W-1:0] holeOfsAddr;
  logic [ADDR_W-1:0] selOfsAddr;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] diff;
  logic [ADDR_W-1:0] nodeRm;
  logic [ADDR_W-1:0] dropCand [3];

  assign holeOfsAddr = ADDR_W'(holeOfs) << HOLE_OFS_SH;
  assign selOfsAddr  = ADDR_W'(selOfs) << SEL_OFS_SH;

  always_comb begin
    case (strb.ofsSel)
      OFS_HOLE: offset = holeOfsAddr;
      OFS_SEL:  offset = selOfsAddr;
      default:  offset = rangeBase;
    endcase
  end

  assign underflow = offset > sysAddr;
  assign diff      = sysAddr - offset;
  assign nodeRm    = ((diff >> (NODE_ILV_LSB + int'(nodeIlvBits))) << NODE_ILV_LSB) | (diff & LOW_KEEP);

  for (genvar g = 0; g < 3; g++) begin : gDrop
    localparam int POS = (g == 0) ? 6 : (g == 1) ? 9 : 12;
    assign dropCand[g] = dropBit(nodeRm, POS);
  end

  always_comb begin
    case (strb.dropSel)
      DROP_B6:  chanAddr = dropCand[0];
      DROP_B9:  chanAddr = dropCand[1];
      DROP_B12: chanAddr = dropCand[2];
      default:  chanAddr = nodeRm;
    endcase
  end
endmodule

// File: rtl/dram_chan_norm.sv
module dram_chan_norm
  import chan_norm_pkg::*;
#(
  parameter  int ADDR_W      = 48,
  parameter  int HOLE_OFS_W  = 9,
  parameter  int HOLE_BASE_W = 8,
  localparam int SEL_BASE_W  = ADDR_W - SEL_BASE_SH,
  localparam int SEL_OFS_W   = ADDR_W - SEL_OFS_SH
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [ADDR_W-1:0]      sysAddr,
  input  logic [1:0]             nodeIlvBits,
  input  logic [ADDR_W-1:0]      rangeBase,
  input  logic                   holeValid,
  input  logic [HOLE_BASE_W-1:0] holeBase,
  input  logic [HOLE_OFS_W-1:0]  holeOfs,
  input  logic                   hiRangeEn,
  input  logic                   hiSel,
  input  logic                   ganged,
  input  logic                   ilvEn,
  input  logic [1:0]             ilvMode,
  input  logic [SEL_BASE_W-1:0]  selBase,
  input  logic [SEL_OFS_W-1:0]   selOfs,
  output logic                   outValid,
  output logic                   chanSel,
  output logic                   hiRange,
  output logic [ADDR_W-1:0]      chanAddr,
  output logic                   underflow
);
  ctrlStrb_t         strb;
  logic [ADDR_W-1:0] nxtAddr;
  logic              nxtUf;

  chan_norm_ctrl #(
    .ADDR_W(ADDR_W), .SEL_BASE_W(SEL_BASE_W), .HOLE_BASE_W(HOLE_BASE_W)
  ) u_ctrl (
    .sysAddr(sysAddr), .nodeIlvBits(nodeIlvBits), .holeValid(holeValid),
    .holeBase(holeBase), .hiRangeEn(hiRangeEn), .hiSel(hiSel), .ganged(ganged),
    .ilvEn(ilvEn), .ilvMode(ilvMode), .selBase(selBase), .strb(strb)
  );

  chan_norm_dpath #(
    .ADDR_W(ADDR_W), .HOLE_OFS_W(HOLE_OFS_W), .SEL_OFS_W(SEL_OFS_W)
  ) u_dpath (
    .sysAddr(sysAddr), .nodeIlvBits(nodeIlvBits), .rangeBase(rangeBase),
    .holeOfs(holeOfs), .selOfs(selOfs), .strb(strb),
    .chanAddr(nxtAddr), .underflow(nxtUf)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      chanSel   <= 1'b0;
      hiRange   <= 1'b0;
      chanAddr  <= '0;
      underflow <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        chanSel   <= strb.chan;
        hiRange   <= strb.hiRange;
        chanAddr  <= nxtAddr;
        underflow <= nxtUf;
      end
    end
  end
endmodule

// File: rtl/chan_norm_chk.sv
module chan_norm_chk
  import chan_norm_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int SEL_BASE_W = 21
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic [ADDR_W-1:0]     sysAddr,
  input logic [ADDR_W-1:0]     rangeBase,
  input logic                  holeValid,
  input logic                  hiRangeEn,
  input logic                  hiSel,
  input logic                  ganged,
  input logic [SEL_BASE_W-1:0] selBase,
  input logic                  outValid,
  input logic                  chanSel,
  input logic                  hiRange,
  input logic [ADDR_W-1:0]     chanAddr,
  input logic                  underflow
);
  logic [ADDR_W-1:0] selBaseAddr;
  assign selBaseAddr = ADDR_W'(selBase) << SEL_BASE_SH;

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_drop_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid && $stable(chanAddr) && $stable(chanSel) && $stable(hiRange));
  assert_hi_pick_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid && hiRangeEn && !ganged && (sysAddr >= selBaseAddr) |=> hiRange && chanSel == $past(hiSel));
  assert_gang_chan_R3: assert property (@(posedge clk) disable iff (!rstN)
    inValid && ganged |=> !hiRange && chanSel == $past(sysAddr[3]));
  assert_low_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid && ganged && !holeValid && rangeBase[11:0] == 12'd0 |=> chanAddr[11:0] == $past(sysAddr[11:0]));
  assert_uf_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    inValid && ganged && !holeValid && (rangeBase > sysAddr) |=> underflow);
endmodule

bind dram_chan_norm chan_norm_chk #(.ADDR_W(ADDR_W), .SEL_BASE_W(SEL_BASE_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .sysAddr(sysAddr), .rangeBase(rangeBase),
  .holeValid(holeValid), .hiRangeEn(hiRangeEn), .hiSel(hiSel), .ganged(ganged),
  .selBase(selBase), .outValid(outValid), .chanSel(chanSel), .hiRange(hiRange),
  .chanAddr(chanAddr), .underflow(underflow)
);

// File: tb/test_dram_chan_norm.sv
`timescale 1ns/1ps
module test_dram_chan_norm;
  localparam int AW = 48;
  localparam logic [63:0] MASK = (64'd1 << AW) - 64'd1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [AW-1:0] sysAddr = '0;
  logic [1:0] nodeIlvBits = '0;
  logic [AW-1:0] rangeBase = '0;
  logic holeValid = 1'b0;
  logic [7:0] holeBase = '0;
  logic [8:0] holeOfs = '0;
  logic hiRangeEn = 1'b0, hiSel = 1'b0, ganged = 1'b0, ilvEn = 1'b0;
  logic [1:0] ilvMode = '0;
  logic [AW-28:0] selBase = '0;
  logic [AW-27:0] selOfs = '0;
  logic outValid, chanSel, hiRange, underflow;
  logic [AW-1:0] chanAddr;

  int vectors = 0;
  int miscompares = 0;
  logic eChan, eHi, eUf;
  logic [63:0] eAddr;

  always #4 clk = ~clk;

  dram_chan_norm i_dram_chan_norm (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sysAddr(sysAddr), .nodeIlvBits(nodeIlvBits),
    .rangeBase(rangeBase), .holeValid(holeValid), .holeBase(holeBase), .holeOfs(holeOfs),
    .hiRangeEn(hiRangeEn), .hiSel(hiSel), .ganged(ganged), .ilvEn(ilvEn), .ilvMode(ilvMode),
    .selBase(selBase), .selOfs(selOfs), .outValid(outValid), .chanSel(chanSel),
    .hiRange(hiRange), .chanAddr(chanAddr), .underflow(underflow)
  );

  // expected result computed from the written requirements
  task automatic model();
    logic [63:0] sa, selB, holeB, holeO, selO, off, d;
    logic par, four;
    int p;
    sa = 64'(sysAddr);
    selB = 64'(selBase) << 27;
    holeB = 64'(holeBase) << 24;
    holeO = 64'(holeOfs) << 23;
    selO = 64'(selOfs) << 26;
    four = sa >= 64'h1_0000_0000;
    eHi = hiRangeEn && !ganged && (sa >= selB);
    par = 1'b0;
    for (int i = 16; i <= 20; i++) par = par ^ sa[i];
    if (ganged) eChan = sa[3];
    else if (eHi) eChan = hiSel;
    else if (ilvEn && ilvMode == 0) eChan = sa[6];
    else if (ilvEn && ilvMode >= 2) eChan = par ^ ((ilvMode == 3) ? sa[9] : sa[6]);
    else if (ilvEn) eChan = sa[12 + nodeIlvBits];
    else if (hiRangeEn) eChan = !hiSel;
    else eChan = 1'b0;
    if (eHi) off = (selB < holeB && holeValid && four) ? holeO : selO;
    else off = (holeValid && four) ? holeO : 64'(rangeBase);
    eUf = off > sa;
    d = (sa - off) & MASK;
    d = ((d >> (12 + nodeIlvBits)) << 12) | (d & 64'hFFF);
    if (ilvEn && !eHi && !ganged) begin
      p = (ilvMode == 0 || ilvMode == 2) ? 6 : (ilvMode == 1) ? 12 : 9;
      d = ((d >> (p + 1)) << p) | (d & ((64'd1 << p) - 64'd1));
    end
    eAddr = d & MASK;
  endtask

  task automatic compare(input string tag, input logic xv, input logic xc, input logic xh,
                         input logic [63:0] xa, input logic xu);
    vectors++;
    if (outValid !== xv || chanSel !== xc || hiRange !== xh || 64'(chanAddr) !== xa || underflow !== xu) begin
      miscompares++;
      $display("FAIL %s: got v=%0b ch=%0b hi=%0b addr=%h uf=%0b, exp v=%0b ch=%0b hi=%0b addr=%h uf=%0b",
               tag, outValid, chanSel, hiRange, chanAddr, underflow, xv, xc, xh, xa, xu);
    end
  endtask

  task automatic clearCfg();
    nodeIlvBits = 0; rangeBase = '0; holeValid = 0; holeBase = 0; holeOfs = 0;
    hiRangeEn = 0; hiSel = 0; ganged = 0; ilvEn = 0; ilvMode = 0; selBase = '0; selOfs = '0;
  endtask

  // drive at negedge, result registered on posedge, sample at next negedge
  task automatic apply(input string tag);
    inValid = 1'b1;
    model();
    @(negedge clk);
    compare(tag, 1'b1, eChan, eHi, eAddr, eUf);
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    repeat (3) @(negedge clk);
    compare("R1 reset", 1'b0, 1'b0, 1'b0, 64'd0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R9: node interleave compaction, hand value
    clearCfg(); sysAddr = 48'h12345; nodeIlvBits = 2;
    inValid = 1'b1; @(negedge clk);
    compare("R9 node drop", 1'b1, 1'b0, 1'b0, 64'h4345, 1'b0);

    // R1: hold with inValid low while inputs change
    inValid = 1'b0; sysAddr = 48'hABCDE; ganged = 1;
    @(negedge clk);
    compare("R1 hold", 1'b0, 1'b0, 1'b0, 64'h4345, 1'b0);

    // R11: range base above address
    clearCfg(); sysAddr = 48'h1000; rangeBase = 48'h2000;
    inValid = 1'b1; @(negedge clk);
    compare("R11 underflow", 1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_F000, 1'b1);

    // R8: hole offset above 4 GiB
    clearCfg(); sysAddr = 48'h1_2000_0000; holeValid = 1; holeOfs = 9'h20; rangeBase = 48'h100;
    inValid = 1'b1; @(negedge clk);
    compare("R8 hole ofs", 1'b1, 1'b0, 1'b0, 64'h1_1000_0000, 1'b0);

    // R8: below 4 GiB uses range base
    sysAddr = 48'hF000_0000;
    inValid = 1'b1; @(negedge clk);
    compare("R8 range base", 1'b1, 1'b0, 1'b0, 64'hEFFF_FF00, 1'b0);

    // R7 / R2: exactly at high range start
    clearCfg(); hiRangeEn = 1; hiSel = 1; selBase = 1; selOfs = 1; sysAddr = 48'h800_0000;
    inValid = 1'b1; @(negedge clk);
    compare("R7 hi base edge", 1'b1, 1'b1, 1'b1, 64'h400_0000, 1'b0);

    // R2 / R4: one below high range start -> inverse select
    sysAddr = 48'h7FF_FFFF;
    inValid = 1'b1; @(negedge clk);
    compare("R2 below edge", 1'b1, 1'b0, 1'b0, 64'h7FF_FFFF, 1'b0);

    // R7: high range with hole applicable
    holeValid = 1; holeBase = 8'hC0; holeOfs = 9'h10; sysAddr = 48'h1_0000_0000;
    inValid = 1'b1; @(negedge clk);
    compare("R7 hi hole", 1'b1, 1'b1, 1'b1, 64'hF800_0000, 1'b0);

    // R6: hash with bit 9, bits 20..16 = 00111 (odd), bit 9 set -> channel 0
    clearCfg(); ilvEn = 1; ilvMode = 3; sysAddr = 48'h7_0200;
    inValid = 1'b1; @(negedge clk);
    compare("R6 hash9", 1'b1, 1'b0, 1'b0, 64'h3_8000, 1'b0);

    // R10: ilv ignored in high range (no bit removed)
    clearCfg(); ilvEn = 1; ilvMode = 0; hiRangeEn = 1; sysAddr = 48'h40;
    inValid = 1'b1; @(negedge clk);
    compare("R10 hi no drop", 1'b1, 1'b0, 1'b1, 64'h40, 1'b0);

    // R3: ganged takes bit 3, no channel drop
    clearCfg(); ganged = 1; ilvEn = 1; hiRangeEn = 1; sysAddr = 48'h48;
    inValid = 1'b1; @(negedge clk);
    compare("R3 ganged", 1'b1, 1'b1, 1'b0, 64'h48, 1'b0);

    // R5 / R10: every mode with every node interleave count
    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 4; n++) begin
        clearCfg(); ilvEn = 1; ilvMode = 2'(m); nodeIlvBits = 2'(n);
        sysAddr = {$urandom, $urandom};
        apply((m >= 2) ? "R6 mode sweep" : "R5 mode sweep");
      end
    end

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      clearCfg();
      sysAddr = {$urandom, $urandom};
      if (r[0]) sysAddr = sysAddr >> (r[5:1] % 16);
      nodeIlvBits = r[7:6];
      rangeBase = r[8] ? 48'({$urandom, $urandom}) >> 12 : 48'($urandom & 32'hFFF_F000);
      holeValid = r[9]; holeBase = 8'($urandom); holeOfs = 9'($urandom);
      hiRangeEn = r[10]; hiSel = r[11]; ganged = r[12] & r[13]; ilvEn = r[14];
      ilvMode = r[16:15];
      selBase = 21'($urandom) >> (r[21:17] % 21);
      selOfs = 22'($urandom);
      model();
      apply(ganged ? "R3 random" : eHi ? "R7 random" : ilvEn ? "R10 random" : "R8 random");
    end

    inValid = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule